// File: doc/BRIEF.md
# Latched Interrupt Status Register with Mask

This block gathers up to `NSRC` active-high interrupt sources into one status register and produces a single interrupt request toward a host link. A source can be a one-cycle pulse or a held level. By default each status bit is sticky: once its source has been high, the bit stays set until the handler clears it. Each bit also has a passthrough control. When that control is set, the bit stops latching and simply tracks the live source.

The block has two clear schemes. In legacy mode the handler clears a bit by writing 1 to it. In message mode a bit clears by itself when the link reports that the interrupt message has gone out. A mask register decides which status bits may drive the request. The request is a level. A run of events that arrives while it is high does not produce a new edge. The request drops only after every unmasked bit has been serviced, so a handler sees one request for each batch of events.

Software reaches the registers through a simple write port and a combinational read port. Status is at address 0, mask at address 1, passthrough at address 2 and control at address 3.

Top module: `irq_latch_ctrl`

## Requirements
- R1: A source high on a bit whose passthrough is 0 sets that status bit at the next clock edge. The bit stays set after the source falls.
- R2: In legacy mode (control bit 0 = 0), a write to address 0 clears each status bit where the write data holds a 1. Bits where the write data holds a 0 keep their value.
- R3: When a source set and a clear reach the same latched bit in the same cycle, the bit ends up set.
- R4: In message mode (control bit 0 = 1), a one-cycle `msg_sent_i` pulse clears every latched status bit whose mask bit is 1. Latched bits whose mask bit is 0 keep their value. Writes to address 0 have no effect in this mode.
- R5: `irq_o` is high exactly when some status bit is 1 and its mask bit is 1. A mask bit of 0 keeps its status bit from raising `irq_o`.
- R6: A status bit whose passthrough bit is 1 equals its source as sampled at the previous clock edge. Neither a clear write nor `msg_sent_i` changes it.
- R7: After reset, status, mask, passthrough and control all read 0. Mask (address 1), passthrough (address 2) and control bit 0 (address 3) read back the value last written.
- R8: While `irq_o` is high, further events and partial clears do not make it drop. It falls only once all unmasked status bits are 0, and only then can it rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Active-high interrupt sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 status, 1 mask, 2 passthrough, 3 control |
| wr_data_i | input | NSRC | Write data |
| rd_addr_i | input | 2 | Read address, same map as the write address |
| rd_data_o | output | NSRC | Combinational read data |
| msg_sent_i | input | 1 | One-cycle pulse: the interrupt message was sent (message mode) |
| irq_o | output | 1 | Combined interrupt request level |

## Verification
A lost latch or a clear applied to the wrong bit shows up at the status read one edge after the event, and at `irq_o` in that same cycle when the bit is unmasked. A wrong mode flag shows up one edge after a write or a send: a status write lands when it should be ignored, or a send leaves a bit set that it should have cleared. A broken passthrough path shows as a status bit that outlives its source by more than one cycle. The bench samples one edge after each stimulus so that each of these faults is caught at its first visible cycle.

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic [1:0]      rd_addr_i,
  output logic [NSRC-1:0] rd_data_o,
  input  logic            msg_sent_i,
  output logic            irq_o
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_PASS = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [NSRC-1:0] stat_q, mask_q, pass_q;
  logic            msg_mode_q;
  logic [NSRC-1:0] clr, stat_d;
  logic            wr_stat;

  assign wr_stat = wr_en_i && (wr_addr_i == A_STAT) && !msg_mode_q;

  always_comb begin
    clr    = (wr_stat ? wr_data_i : '0) | ((msg_mode_q && msg_sent_i) ? mask_q : '0);
    stat_d = (pass_q & src_i) | (~pass_q & (src_i | (stat_q & ~clr)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      mask_q     <= '0;
      pass_q     <= '0;
      msg_mode_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_en_i) begin
        case (wr_addr_i)
          A_MASK:  mask_q     <= wr_data_i;
          A_PASS:  pass_q     <= wr_data_i;
          A_CTRL:  msg_mode_q <= wr_data_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_STAT:  rd_data_o = stat_q;
      A_MASK:  rd_data_o = mask_q;
      A_PASS:  rd_data_o = pass_q;
      default: rd_data_o[0] = msg_mode_q;
    endcase
  end

  assign irq_o = |(stat_q & mask_q);

  // R1, and R3: a set that meets a clear in the same cycle still lands
  assert_sticky_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & ~pass_q) != '0) |=>
      ((stat_q & $past(src_i & ~pass_q)) == $past(src_i & ~pass_q)));

  assert_hold_no_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !msg_sent_i) |=>
      ((stat_q & $past(stat_q & ~pass_q)) == $past(stat_q & ~pass_q)));

  assert_msg_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_mode_q && msg_sent_i) |=>
      ((stat_q & $past(mask_q & ~pass_q & ~src_i)) == '0));

  assert_pass_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(pass_q)) == ($past(src_i) & $past(pass_q))));

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((stat_q & mask_q) == '0));
endmodule

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [N-1:0] rd_data;
  logic msg_sent = 1'b0;
  logic irq;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  irq_latch_ctrl #(.NSRC(N)) i_irq_latch_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .msg_sent_i(msg_sent), .irq_o(irq));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [N-1:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R7 reset value", d, '0);
    end
    chk("R5 irq after reset", {31'b0, irq}, '0);
  endtask

  task automatic t_regs;
    logic [N-1:0] d;
    wr(2'd1, 32'hAAAA_5555); rd(2'd1, d); chk("R7 mask readback", d, 32'hAAAA_5555);
    wr(2'd2, 32'h0F0F_0001); rd(2'd2, d); chk("R7 pass readback", d, 32'h0F0F_0001);
    wr(2'd3, 32'h1);         rd(2'd3, d); chk("R7 ctrl readback", d, 32'h1);
    wr(2'd3, 32'h0); wr(2'd1, '0); wr(2'd2, '0);
    rd(2'd3, d); chk("R7 ctrl cleared", d, '0);
  endtask

  task automatic t_latch;
    logic [N-1:0] d;
    pulse(32'h8);
    @(negedge clk);
    rd(2'd0, d); chk("R1 sticky after pulse", d, 32'h8);
    chk("R5 masked bit gives no irq", {31'b0, irq}, '0);
    wr(2'd1, 32'h8);
    chk("R5 unmasked bit raises irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c;
    logic [N-1:0] d;
    wr(2'd0, 32'h8);
    rd(2'd0, d); chk("R2 clear by write 1", d, '0);
    chk("R5 irq drops after clear", {31'b0, irq}, '0);
    pulse(32'h6);
    wr(2'd1, 32'h6);
    wr(2'd0, 32'h2);
    rd(2'd0, d); chk("R2 only written bit cleared", d, 32'h4);
    chk("R8 partial clear keeps irq", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h4);
    chk("R8 irq falls when all clear", {31'b0, irq}, '0);
  endtask

  task automatic t_collide;
    logic [N-1:0] d;
    pulse(32'h20);
    @(negedge clk);
    src = 32'h20; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h20;
    @(negedge clk);
    src = '0; wr_en = 1'b0; wr_data = '0;
    rd(2'd0, d); chk("R3 set wins over clear", d, 32'h20);
    wr(2'd0, 32'h20);
  endtask

  task automatic t_batch;
    logic [N-1:0] d;
    wr(2'd1, 32'h3);
    pulse(32'h1);
    chk("R8 first event raises irq", {31'b0, irq}, 32'h1);
    @(negedge clk); src = 32'h2;
    @(negedge clk); src = '0;
    chk("R8 second event keeps irq high", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h1);
    chk("R8 irq held with bit left", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h2);
    chk("R8 irq low after batch", {31'b0, irq}, '0);
    rd(2'd0, d); chk("R2 status empty after batch", d, '0);
  endtask

  task automatic t_msg;
    logic [N-1:0] d;
    wr(2'd3, 32'h1);
    wr(2'd1, 32'h1);
    pulse(32'h11);
    wr(2'd0, 32'h11);
    rd(2'd0, d); chk("R4 status write ignored", d, 32'h11);
    @(negedge clk); msg_sent = 1'b1;
    @(negedge clk); msg_sent = 1'b0;
    rd(2'd0, d); chk("R4 send clears unmasked only", d, 32'h10);
    chk("R4 irq low after send", {31'b0, irq}, '0);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h10);
    rd(2'd0, d); chk("R2 legacy restored", d, '0);
  endtask

  task automatic t_pass;
    logic [N-1:0] d;
    wr(2'd2, 32'h80);
    @(negedge clk); src = 32'h80;
    @(negedge clk);
    rd(2'd0, d); chk("R6 follows source high", d, 32'h80);
    wr(2'd0, 32'h80);
    rd(2'd0, d); chk("R6 clear write no effect", d, 32'h80);
    src = '0;
    @(negedge clk);
    rd(2'd0, d); chk("R6 drops with source", d, '0);
    wr(2'd2, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_latch();
    t_w1c();
    t_collide();
    t_batch();
    t_msg();
    t_pass();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule